// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block is a register-mapped timer unit with several independent down-counting channels. Each channel holds a control word, an interval (reload) value and a readable current count. A channel counts down on the tick enable chosen by its source field: a main tick, an alternate tick or a slow (32768 Hz) tick. A power-of-two prescaler can slow that tick further. When a channel expires it raises its bit in a shared pending register. The single interrupt output is the OR of every pending bit gated by its enable bit.

The slow tick comes either from an external crystal tick input or from an internal tick input. A key-protected control register makes that choice. With automatic fallback enabled, a selected but silent external source is treated as absent and the internal tick is used. Software uses the block through a single-cycle bus. A write lands on the clock edge, and read data is combinational from the address in the same cycle. A channel loaded with an all-ones interval and run in continuous mode is a free-running counter whose complement serves as an up-counting timestamp.

Top module: `tmr_unit`

## Requirements
- R1: After reset, every readable register (interrupt enable, pending, every channel's control, interval and current value, low-speed control) reads 0, and `irq` is 0.
- R2: Address map (byte addresses):
  - Interrupt enable is at 0x00, bit n for channel n.
  - Pending is at 0x04, bit n for channel n.
  - Channel n has its control word at 0x10 + 0x20·n, its interval at control+4 and its current value at control+8. The current value is read-only.
  - Low-speed control is at 0x100.
- R3: Control word fields:
  - Bit 0 is enable.
  - Bit 1 is reload and always reads 0.
  - Bits 3:2 are the source: 1 = main tick, 2 = alternate tick, 0 or 3 = slow tick.
  - Bits 6:4 are the prescale p.
  - Bit 7 = 1 selects one-shot; bit 7 = 0 selects continuous.
- R4: A control write with bit 1 set, or one that turns enable from 0 to 1, copies the interval into the current value at that write's clock edge.
- R5: While enabled, the current value drops by one on every 2^p-th selected tick counted from the last load. Ticks from sources not selected have no effect.
- R6: In continuous mode, a divided tick that finds the current value at 1 or 0 sets the channel's pending bit on that edge and reloads the current value from the interval.
- R7: In one-shot mode, expiry sets the pending bit, clears the enable bit and leaves the current value at 0. Further ticks do not change it.
- R8: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged. An expiry in the same cycle as a clear leaves the bit set.
- R9: `irq` is 1 exactly when some channel has both its pending bit and its enable bit set.
- R10: A write to low-speed control takes effect only when bits 31:16 equal 0x16aa; otherwise the register is unchanged. Bit 14 enables fallback and bit 0 selects the external slow tick. The key field reads back 0.
- R11: The external source counts as present for LS_TIMEOUT cycles after each external tick. When it is selected, absent and fallback is enabled, bit 0 reads 0.
- R12: Slow-source channels count external ticks when the readable bit 0 of low-speed control is 1, and internal ticks otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, data lands on this edge |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| main_tick | input | 1 | Main-clock tick enable |
| alt_tick | input | 1 | Alternate-clock tick enable |
| slow_int_tick | input | 1 | Internal 32 kHz tick enable |
| slow_ext_tick | input | 1 | External 32 kHz tick enable |
| irq | output | 1 | Combined interrupt |

## Verification
Read data is combinational, so every register result is due in the same cycle that the address is presented, one edge after the write that set it. Counter loads, decrements, expiry, pending set and enable clear all take effect on the same edge as the write or tick that causes them, and `irq` follows pending in the same cycle. The bench drives a write or a tick for exactly one rising edge from the falling edge before it, then reads back at the next falling edge. Each check therefore lands one edge after its cause. The prescaler sweep compares every single tick against 20 − ⌊t/2^p⌋.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        SRC_SLOW  = 2'd0,
        SRC_MAIN  = 2'd1,
        SRC_ALT   = 2'd2,
        SRC_SLOW3 = 2'd3
    } tmr_src_e;

    typedef struct packed {
        logic     oneshot;
        logic [2:0] pre;
        tmr_src_e src;
        logic     en;
    } tmr_ctrl_t;

    localparam int IEN_ADDR  = 'h00;
    localparam int PEND_ADDR = 'h04;
    localparam int CH_BASE   = 'h10;
    localparam int CH_STRIDE = 'h20;
    localparam int OFF_INTV  = 4;
    localparam int OFF_CUR   = 8;
    localparam int LS_ADDR   = 'h100;
    localparam logic [15:0] LS_KEY = 16'h16aa;

    function automatic tmr_ctrl_t unpack_ctrl(input logic [7:0] w);
        tmr_ctrl_t c;
        c.oneshot = w[7];
        c.pre     = w[6:4];
        c.src     = tmr_src_e'(w[3:2]);
        c.en      = w[0];
        return c;
    endfunction

    function automatic logic [31:0] pack_ctrl(input tmr_ctrl_t c);
        return {24'd0, c.oneshot, c.pre, c.src, 1'b0, c.en};
    endfunction

    function automatic logic [6:0] pre_mask(input logic [2:0] p);
        return (7'd1 << p) - 7'd1;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       tick,
    input  logic [2:0] pre,
    output logic       dtick
);
    logic [6:0] pcnt;
    logic [6:0] mask;

    assign mask  = pre_mask(pre);
    assign dtick = tick && ((pcnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clr)
            pcnt <= '0;
        else if (tick)
            pcnt <= pcnt + 7'd1;
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic [7:0]       ctrl_wdata,
    input  logic             intv_we,
    input  logic [CNT_W-1:0] intv_wdata,
    input  logic             main_tick,
    input  logic             alt_tick,
    input  logic             slow_tick,
    output logic [31:0]      ctrl_rd,
    output logic [CNT_W-1:0] intv_rd,
    output logic [CNT_W-1:0] cur,
    output logic             expire
);
    tmr_ctrl_t        ctrl;
    tmr_ctrl_t        ctrl_new;
    logic [CNT_W-1:0] intv;
    logic             load;
    logic             src_tick;
    logic             dtick;
    logic             at_end;

    assign ctrl_new = unpack_ctrl(ctrl_wdata);
    assign load     = ctrl_we && (ctrl_wdata[1] || (ctrl_new.en && !ctrl.en));
    assign at_end   = (cur <= CNT_W'(1));
    assign expire   = ctrl.en && dtick && !load && at_end;
    assign ctrl_rd  = pack_ctrl(ctrl);
    assign intv_rd  = intv;

    always_comb begin
        case (ctrl.src)
            SRC_MAIN: src_tick = main_tick;
            SRC_ALT:  src_tick = alt_tick;
            default:  src_tick = slow_tick;
        endcase
    end

    tmr_prescaler u_pre (
        .clk   (clk),
        .rst   (rst),
        .clr   (load),
        .tick  (src_tick && ctrl.en),
        .pre   (ctrl.pre),
        .dtick (dtick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            intv <= '0;
            cur  <= '0;
        end else begin
            if (intv_we)
                intv <= intv_wdata;
            if (ctrl_we)
                ctrl <= ctrl_new;
            else if (expire && ctrl.oneshot)
                ctrl.en <= 1'b0;
            if (load)
                cur <= intv;
            else if (expire)
                cur <= ctrl.oneshot ? '0 : intv;
            else if (ctrl.en && dtick)
                cur <= cur - CNT_W'(1);
        end
    end

    assert_load_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> (cur == $past(intv)));

    assert_decrement_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && dtick && !load && !at_end) |=> (cur == $past(cur) - CNT_W'(1)));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!load && !(ctrl.en && dtick)) |=> $stable(cur));

    assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (rst)
        (expire && ctrl.oneshot && !ctrl_we) |=> (!ctrl.en && cur == '0));
endmodule

// File: rtl/tmr_lsclk.sv
module tmr_lsclk
    import tmr_pkg::*;
#(
    parameter int TIMEOUT = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [15:0] key,
    input  logic        fb_in,
    input  logic        sel_in,
    input  logic        ext_tick,
    output logic [31:0] rd_word,
    output logic        use_ext
);
    localparam int TW = $clog2(TIMEOUT + 1);

    logic          auto_fb;
    logic          sel;
    logic [TW-1:0] quiet;
    logic          present;

    assign present = (quiet < TW'(TIMEOUT));
    assign use_ext = sel && (present || !auto_fb);
    assign rd_word = {17'd0, auto_fb, 13'd0, use_ext};

    always_ff @(posedge clk) begin
        if (rst) begin
            auto_fb <= 1'b0;
            sel     <= 1'b0;
        end else if (we && key == LS_KEY) begin
            auto_fb <= fb_in;
            sel     <= sel_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            quiet <= TW'(TIMEOUT);
        else if (ext_tick)
            quiet <= '0;
        else if (quiet < TW'(TIMEOUT))
            quiet <= quiet + TW'(1);
    end

    assert_bad_key_R10: assert property (@(posedge clk) disable iff (rst)
        (we && key != LS_KEY) |=> ($stable(sel) && $stable(auto_fb)));

    assert_fallback_R11: assert property (@(posedge clk) disable iff (rst)
        (sel && auto_fb && !present) |-> !use_ext);
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int NUM_CH     = 3,
    parameter int CNT_W      = 32,
    parameter int ADDR_W     = 12,
    parameter int LS_TIMEOUT = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              main_tick,
    input  logic              alt_tick,
    input  logic              slow_int_tick,
    input  logic              slow_ext_tick,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(IEN_ADDR);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(PEND_ADDR);
    localparam logic [ADDR_W-1:0] A_LS   = ADDR_W'(LS_ADDR);

    logic [NUM_CH-1:0] ien;
    logic [NUM_CH-1:0] pend;
    logic [NUM_CH-1:0] expire;
    logic [31:0]       ctrl_rd [NUM_CH];
    logic [CNT_W-1:0]  intv_rd [NUM_CH];
    logic [CNT_W-1:0]  cur_rd  [NUM_CH];
    logic [31:0]       ls_rd;
    logic              use_ext;
    logic              slow_tick;
    logic              pend_clr_we;

    assign slow_tick   = use_ext ? slow_ext_tick : slow_int_tick;
    assign pend_clr_we = bus_we && bus_addr == A_PEND;
    assign irq         = |(pend & ien);

    tmr_lsclk #(.TIMEOUT(LS_TIMEOUT)) u_ls (
        .clk      (clk),
        .rst      (rst),
        .we       (bus_we && bus_addr == A_LS),
        .key      (bus_wdata[31:16]),
        .fb_in    (bus_wdata[14]),
        .sel_in   (bus_wdata[0]),
        .ext_tick (slow_ext_tick),
        .rd_word  (ls_rd),
        .use_ext  (use_ext)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(CH_BASE + i * CH_STRIDE);
        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .ctrl_we    (bus_we && bus_addr == BASE),
            .ctrl_wdata (bus_wdata[7:0]),
            .intv_we    (bus_we && bus_addr == BASE + ADDR_W'(OFF_INTV)),
            .intv_wdata (bus_wdata[CNT_W-1:0]),
            .main_tick  (main_tick),
            .alt_tick   (alt_tick),
            .slow_tick  (slow_tick),
            .ctrl_rd    (ctrl_rd[i]),
            .intv_rd    (intv_rd[i]),
            .cur        (cur_rd[i]),
            .expire     (expire[i])
        );

        assert_pend_set_R6: assert property (@(posedge clk) disable iff (rst)
            expire[i] |=> pend[i]);

        assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
            (pend_clr_we && bus_wdata[i] && !expire[i]) |=> !pend[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien  <= '0;
            pend <= '0;
        end else begin
            if (bus_we && bus_addr == A_IEN)
                ien <= bus_wdata[NUM_CH-1:0];
            pend <= (pend & ~(pend_clr_we ? bus_wdata[NUM_CH-1:0] : '0)) | expire;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_IEN)  bus_rdata = 32'(ien);
        if (bus_addr == A_PEND) bus_rdata = 32'(pend);
        if (bus_addr == A_LS)   bus_rdata = ls_rd;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(CH_BASE + i * CH_STRIDE))
                bus_rdata = ctrl_rd[i];
            if (bus_addr == ADDR_W'(CH_BASE + i * CH_STRIDE + OFF_INTV))
                bus_rdata = 32'(intv_rd[i]);
            if (bus_addr == ADDR_W'(CH_BASE + i * CH_STRIDE + OFF_CUR))
                bus_rdata = 32'(cur_rd[i]);
        end
    end

    assert_irq_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(pend_clr_we) || $past(bus_we) || $past(|expire)));
endmodule

// File: tb/sim_tmr_unit.sv
module sim_tmr_unit;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  tk = '0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tmr_unit #(.NUM_CH(3), .CNT_W(32), .ADDR_W(12), .LS_TIMEOUT(TMO)) u0 (
        .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .main_tick(tk[0]), .alt_tick(tk[1]),
        .slow_int_tick(tk[2]), .slow_ext_tick(tk[3]), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit with_tick = 0);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d; tk[0] = with_tick;
        @(negedge clk);
        we = 1'b0; tk[0] = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic ticks(input int which, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tk[which] = 1'b1;
            @(negedge clk); tk[which] = 1'b0;
        end
    endtask

    task automatic expect_rd(input string req, input logic [11:0] a, input logic [31:0] e);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, e);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_rd("R1 ien", 12'h000, 0);
        expect_rd("R1 pend", 12'h004, 0);
        for (int c = 0; c < 3; c++) begin
            expect_rd("R1 ctrl", 12'(16 + 32 * c), 0);
            expect_rd("R1 intv", 12'(20 + 32 * c), 0);
            expect_rd("R1 cur", 12'(24 + 32 * c), 0);
        end
        expect_rd("R1 ls", 12'h100, 0);
        chk("R1 irq", 32'(irq), 0);

        // R2 R4 enable loads interval
        wr(12'h014, 5);
        expect_rd("R2 intv0", 12'h014, 5);
        wr(12'h010, 32'h05);
        expect_rd("R4 load on enable", 12'h018, 5);
        wr(12'h018, 32'h99);
        expect_rd("R2 cur read-only", 12'h018, 5);

        // R5 prescale sweep on channel 0
        for (int p = 0; p < 4; p++) begin
            wr(12'h010, 0);
            wr(12'h014, 20);
            wr(12'h010, 32'h05 | (p << 4));
            expect_rd("R3 ctrl fields", 12'h010, 32'h05 | (p << 4));
            for (int t = 1; t <= 12; t++) begin
                ticks(0, 1);
                expect_rd("R5 prescale count", 12'h018, 20 - (t >> p));
            end
        end
        ticks(1, 3);
        expect_rd("R5 unselected source ignored", 12'h018, 20 - (12 >> 3));

        // R6 continuous expiry
        wr(12'h010, 0);
        wr(12'h014, 3);
        wr(12'h010, 32'h05);
        ticks(0, 2);
        expect_rd("R6 no pend yet", 12'h004, 0);
        ticks(0, 1);
        expect_rd("R6 pend set", 12'h004, 1);
        expect_rd("R6 reload", 12'h018, 3);
        chk("R9 irq off when disabled", 32'(irq), 0);
        wr(12'h000, 2);
        chk("R9 irq other enable", 32'(irq), 0);
        wr(12'h000, 1);
        #1 chk("R9 irq on", 32'(irq), 1);

        // R8 write-one-to-clear
        wr(12'h004, 0);
        expect_rd("R8 zero write keeps", 12'h004, 1);
        wr(12'h004, 1);
        expect_rd("R8 one write clears", 12'h004, 0);
        chk("R9 irq clears", 32'(irq), 0);
        ticks(0, 2);
        wr(12'h004, 1, 1'b1);
        expect_rd("R8 set wins over clear", 12'h004, 1);
        wr(12'h004, 1);

        // R7 one-shot
        wr(12'h010, 0);
        wr(12'h014, 2);
        wr(12'h010, 32'h85);
        ticks(0, 1);
        expect_rd("R7 counting", 12'h018, 1);
        ticks(0, 1);
        expect_rd("R7 enable cleared", 12'h010, 32'h84);
        expect_rd("R7 cur zero", 12'h018, 0);
        expect_rd("R7 pend", 12'h004, 1);
        wr(12'h004, 1);
        ticks(0, 2);
        expect_rd("R7 stays stopped", 12'h018, 0);
        expect_rd("R7 no new pend", 12'h004, 0);

        // R3 R4 channel 1 on alternate tick, reload bit
        wr(12'h034, 9);
        wr(12'h030, 32'h09);
        ticks(0, 3);
        expect_rd("R3 main ignored by alt channel", 12'h038, 9);
        ticks(1, 2);
        expect_rd("R3 alt source counts", 12'h038, 7);
        wr(12'h030, 32'h0B);
        expect_rd("R4 reload bit loads", 12'h038, 9);
        expect_rd("R3 reload reads zero", 12'h030, 32'h09);

        // R10 R11 R12 low-speed control and slow channel 2
        wr(12'h100, 32'h1234_4001);
        expect_rd("R10 bad key ignored", 12'h100, 0);
        wr(12'h100, 32'h16aa_4001);
        expect_rd("R11 absent falls back", 12'h100, 32'h4000);
        wr(12'h054, 50);
        wr(12'h050, 32'h01);
        ticks(2, 2);
        expect_rd("R12 internal during fallback", 12'h058, 48);
        ticks(3, 1);
        expect_rd("R12 ext not yet selected", 12'h058, 48);
        expect_rd("R11 present reads one", 12'h100, 32'h4001);
        ticks(3, 3);
        expect_rd("R12 external counts", 12'h058, 45);
        ticks(2, 2);
        expect_rd("R12 internal ignored", 12'h058, 45);
        wr(12'h100, 32'h0000_0000);
        expect_rd("R10 bad key keeps value", 12'h100, 32'h4001);
        wr(12'h100, 32'h16aa_0000);
        expect_rd("R10 key write internal", 12'h100, 0);
        ticks(3, 2);
        expect_rd("R12 ext ignored when internal", 12'h058, 45);
        ticks(2, 1);
        expect_rd("R12 internal counts", 12'h058, 44);
        repeat (TMO + 4) @(negedge clk);
        wr(12'h100, 32'h16aa_0001);
        expect_rd("R11 no fallback keeps select", 12'h100, 32'h0001);

        report();
    end
endmodule